// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns two active-low external request pins into interrupt requests for a processor core. Each channel has a sense-mode bit. With the bit at 0 the channel is level-sensed: its request follows the synchronized pin and stays active for as long as the pin is held low. With the bit at 1 the channel is edge-sensed: a falling edge on the pin sets a sticky pending flag. The flag remains set until the core acknowledges the interrupt or software rewrites it.

Both pins are asynchronous. Each one passes through a two-flop synchronizer before any sensing is done. The sense-mode bits and the pending flags of both channels share one 4-bit control nibble, which is read and written through a simple register port. The acknowledge inputs are driven by the interrupt controller when it takes a channel's request. Priority resolution and vector generation happen outside this block.

Top module: `xint_sense`

## Requirements
- R1: While reset is high, and at the first sample after it is released, both requests are 0 and the control nibble reads 0. A 0 in a mode bit means level sensing, so both channels start in level mode with nothing pending.
- R2: The control nibble layout is: bit 0 is the channel 0 sense mode, bit 1 is the channel 0 pending flag, bit 2 is the channel 1 sense mode and bit 3 is the channel 1 pending flag. A mode bit of 1 selects edge sensing. A write to the nibble updates the mode bits on the next clock edge, and the read port always shows the current mode and flag of both channels.
- R3: In edge mode, if a pin is driven low before clock edge n, after being high for at least three edges, the channel's request rises after edge n+2 and not earlier. A rising edge on the pin never sets the flag.
- R4: In edge mode the pending flag, which is also the request output, stays set after the pin returns high. It holds until an acknowledge or a software write changes it.
- R5: In edge mode, an acknowledge pulse on a channel clears its flag on the next clock edge, unless a new edge arrives on that same edge.
- R6: If a falling edge is detected in the same cycle as that channel's acknowledge, the flag stays set, so the new request is not lost.
- R7: In edge mode, writing the nibble loads each channel's flag from its flag bit, which can set or clear it. A falling edge detected in the same cycle takes precedence over a written 0.
- R8: In level mode the request is the inverse of the synchronized pin. It rises after edge n+2 when the pin goes low before edge n, and it falls with the same latency when the pin returns high. Acknowledges and flag-bit writes have no effect in this mode.
- R9: The two channels operate independently. Inputs to one channel never change the request, flag or mode of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 2 | Active-low asynchronous request pins, bit i for channel i |
| ack | input | 2 | Interrupt acknowledge, bit i for channel i |
| reg_wr_en | input | 1 | Write strobe for the control nibble |
| reg_wdata | input | 4 | Control nibble write data |
| reg_rdata | output | 4 | Control nibble read data |
| req | output | 2 | Interrupt request per channel, active high |

## Verification
The assertions assume that the acknowledge and write inputs are synchronous to the clock. They also look at the synchronized pin and at the registered falling-edge strobe, so the raw asynchronous pins are never sampled directly. The stimulus follows these assumptions: every input, including the pins, changes only at the falling clock edge. Pins, acknowledges and writes are drawn at random, in different proportions, for each channel independently. This produces coincidences such as an acknowledge in the same cycle as an edge, a write in the same cycle as an edge, and single-cycle pin pulses. Directed sequences pin down the exact three-edge latency and the same-cycle precedence cases.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    // Per-channel field pair in the control nibble: {flag, mode}
    typedef struct packed {
        logic   flag;
        sense_e mode;
    } chan_ctl_t;

    localparam int unsigned CTL_W    = $bits(chan_ctl_t);
    localparam int unsigned SYNC_MIN = 2;

    // Next pending-flag value; edge beats write beats acknowledge.
    function automatic logic flag_next(
        input sense_e mode,
        input logic   flag,
        input logic   fall_hit,
        input logic   pin_low,
        input logic   wr,
        input logic   wr_flag,
        input logic   ack
    );
        logic nxt;
        if (mode == SENSE_LEVEL)  nxt = pin_low;
        else if (fall_hit)        nxt = 1'b1;
        else if (wr)              nxt = wr_flag;
        else if (ack)             nxt = 1'b0;
        else                      nxt = flag;
        return nxt;
    endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    import xint_pkg::*;

    localparam int unsigned N = (STAGES < SYNC_MIN) ? SYNC_MIN : STAGES;

    logic [N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {N{RST_VAL}};
        else     chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/xint_fall_det.sv
module xint_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic s,
    output logic fall
);
    logic prev;

    // Idle level is high, so reset the history high to avoid a false edge.
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= s;
    end

    assign fall = prev & ~s;
endmodule

// File: rtl/xint_chan.sv
module xint_chan #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pin_n,
    input  logic                 ack,
    input  logic                 wr_en,
    input  xint_pkg::chan_ctl_t  wr_val,
    output xint_pkg::chan_ctl_t  ctl_q,
    output logic                 pin_s,
    output logic                 fall,
    output logic                 req
);
    import xint_pkg::*;

    xint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_n),
        .q   (pin_s)
    );

    xint_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .s    (pin_s),
        .fall (fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{flag: 1'b0, mode: SENSE_LEVEL};
        end else begin
            ctl_q.mode <= wr_en ? wr_val.mode : ctl_q.mode;
            ctl_q.flag <= flag_next(ctl_q.mode, ctl_q.flag, fall, ~pin_s,
                                    wr_en, wr_val.flag, ack);
        end
    end

    assign req = ctl_q.flag;
endmodule

// File: rtl/xint_sense.sv
module xint_sense #(
    parameter int unsigned NCH         = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NCH-1:0]                      pin_n,
    input  logic [NCH-1:0]                      ack,
    input  logic                                reg_wr_en,
    input  logic [NCH*xint_pkg::CTL_W-1:0]      reg_wdata,
    output logic [NCH*xint_pkg::CTL_W-1:0]      reg_rdata,
    output logic [NCH-1:0]                      req
);
    import xint_pkg::*;

    localparam int unsigned REG_W = NCH * CTL_W;

    chan_ctl_t       ctl_w [NCH];
    logic [NCH-1:0]  pin_s;
    logic [NCH-1:0]  fall;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_ctl_t wr_val;
        assign wr_val = chan_ctl_t'(reg_wdata[i*CTL_W +: CTL_W]);

        xint_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .pin_n  (pin_n[i]),
            .ack    (ack[i]),
            .wr_en  (reg_wr_en),
            .wr_val (wr_val),
            .ctl_q  (ctl_w[i]),
            .pin_s  (pin_s[i]),
            .fall   (fall[i]),
            .req    (req[i])
        );

        assign reg_rdata[i*CTL_W +: CTL_W] = ctl_w[i];
    end

    logic unused_ok;
    assign unused_ok = (REG_W == 0);
endmodule

// File: rtl/xint_sense_chk.sv
module xint_sense_chk #(
    parameter int unsigned NCH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   ack,
    input logic             wr_en,
    input logic [2*NCH-1:0] wdata,
    input logic [2*NCH-1:0] rdata,
    input logic [NCH-1:0]   req,
    input logic [NCH-1:0]   pin_s,
    input logic [NCH-1:0]   fall
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (req == '0 && rdata == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R8
        level_follow_chk: assert property (@(posedge clk) disable iff (rst)
            !rdata[2*i] |=> (req[i] == !$past(pin_s[i])));
        // R3
        edge_set_chk: assert property (@(posedge clk) disable iff (rst)
            (rdata[2*i] && fall[i]) |=> req[i]);
        // R5
        ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (rdata[2*i] && ack[i] && !fall[i] && !wr_en) |=> !req[i]);
        // R4
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (rdata[2*i] && !ack[i] && !fall[i] && !wr_en) |=> (req[i] == $past(req[i])));
        // R7
        write_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (rdata[2*i] && wr_en && !fall[i]) |=> (req[i] == $past(wdata[2*i+1])));
        // R2
        mode_write_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> (rdata[2*i] == $past(wdata[2*i])));
    end
endmodule

bind xint_sense xint_sense_chk #(.NCH(NCH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ack   (ack),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .req   (req),
    .pin_s (pin_s),
    .fall  (fall)
);

// File: tb/xint_sense_tb.sv
module xint_sense_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pin_n = 2'b11;
    logic [1:0] ack = 2'b00;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic [1:0] req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xint_sense #(.NCH(NCH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (pin_n),
        .ack       (ack),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req       (req)
    );

    // Reference model built from the requirements (R3, R5..R8)
    logic [1:0] m_a, m_b, m_prev, m_mode, m_flag;
    always @(posedge clk) begin
        if (rst) begin
            m_a <= 2'b11; m_b <= 2'b11; m_prev <= 2'b11;
            m_mode <= 2'b00; m_flag <= 2'b00;
        end else begin
            m_a <= pin_n; m_b <= m_a; m_prev <= m_b;
            for (int i = 0; i < 2; i++) begin
                if (reg_wr_en) m_mode[i] <= reg_wdata[2*i];
                if (!m_mode[i])                m_flag[i] <= !m_b[i];
                else if (m_prev[i] && !m_b[i]) m_flag[i] <= 1'b1;
                else if (reg_wr_en)            m_flag[i] <= reg_wdata[2*i+1];
                else if (ack[i])               m_flag[i] <= 1'b0;
            end
        end
    end

    function automatic logic [3:0] exp_nibble(input logic [1:0] mode, input logic [1:0] flag);
        return {flag[1], mode[1], flag[0], mode[0]};
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs for one cycle; return at the following falling edge.
    task automatic cyc(input logic [1:0] p, input logic [1:0] a, input logic w, input logic [3:0] d);
        pin_n = p; ack = a; reg_wr_en = w; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ack = 2'b00; reg_wr_en = 1'b0;
    endtask

    task automatic idle(input logic [1:0] p, input int n);
        for (int k = 0; k < n; k++) cyc(p, 2'b00, 1'b0, 4'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 req in reset", {2'b00, req}, 4'h0);
        chk("R1 nibble in reset", reg_rdata, 4'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 nibble after reset", reg_rdata, 4'h0);

        // Level mode on channel 0
        cyc(2'b10, 2'b00, 1'b0, 4'h0);
        chk("R8 level latency e1", {2'b00, req}, 4'h0);
        cyc(2'b10, 2'b00, 1'b0, 4'h0);
        chk("R8 level latency e2", {2'b00, req}, 4'h0);
        cyc(2'b10, 2'b00, 1'b0, 4'h0);
        chk("R8 level req up", {2'b00, req}, 4'h1);
        chk("R8 level nibble", reg_rdata, 4'b0010);
        cyc(2'b10, 2'b00, 1'b1, 4'b0000);
        chk("R8 flag write ignored", {2'b00, req}, 4'h1);
        cyc(2'b10, 2'b01, 1'b0, 4'h0);
        chk("R8 ack ignored", {2'b00, req}, 4'h1);
        idle(2'b11, 2);
        chk("R8 release latency", {2'b00, req}, 4'h1);
        idle(2'b11, 1);
        chk("R8 released", {2'b00, req}, 4'h0);

        // Both channels to edge mode
        cyc(2'b11, 2'b00, 1'b1, 4'b0101);
        chk("R2 mode readback", reg_rdata, 4'b0101);

        // Channel 1 falling edge
        idle(2'b01, 2);
        chk("R3 edge latency", {2'b00, req}, 4'h0);
        idle(2'b01, 1);
        chk("R3 edge sets flag", {2'b00, req}, 4'h2);
        chk("R9 channel 0 untouched", {3'b000, req[0]}, 4'h0);
        chk("R2 flag readback", reg_rdata, 4'b1101);
        idle(2'b11, 4);
        chk("R4 flag sticky", {2'b00, req}, 4'h2);
        cyc(2'b11, 2'b10, 1'b0, 4'h0);
        chk("R5 ack clears", {2'b00, req}, 4'h0);
        chk("R5 nibble after ack", reg_rdata, 4'b0101);

        // Rising edge must not set the flag
        idle(2'b01, 4);
        cyc(2'b01, 2'b10, 1'b0, 4'h0);
        idle(2'b11, 4);
        chk("R3 rising ignored", {2'b00, req}, 4'h0);

        // Software write set/clear
        cyc(2'b11, 2'b00, 1'b1, 4'b0111);
        chk("R7 write sets", reg_rdata, 4'b0111);
        cyc(2'b11, 2'b00, 1'b1, 4'b0101);
        chk("R7 write clears", {2'b00, req}, 4'h0);

        // Edge coincident with acknowledge
        idle(2'b10, 2);
        cyc(2'b10, 2'b01, 1'b0, 4'h0);
        chk("R6 edge beats ack", {2'b00, req}, 4'h1);
        cyc(2'b10, 2'b01, 1'b0, 4'h0);
        chk("R5 later ack clears", {2'b00, req}, 4'h0);
        idle(2'b11, 3);

        // Edge coincident with write of 0
        idle(2'b10, 2);
        cyc(2'b10, 2'b00, 1'b1, 4'b0101);
        chk("R7 edge beats write 0", {2'b00, req}, 4'h1);
        idle(2'b11, 3);
        cyc(2'b11, 2'b01, 1'b0, 4'h0);
        chk("R5 cleared again", {2'b00, req}, 4'h0);

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] p;
            logic [1:0] a;
            logic       w;
            p = pin_n;
            for (int i = 0; i < 2; i++) begin
                if ($urandom_range(3) == 0) p[i] = ~p[i];
                a[i] = ($urandom_range(5) == 0);
            end
            w = ($urandom_range(9) == 0);
            cyc(p, a, w, 4'($urandom_range(15)));
            chk("R9 random req", {2'b00, req}, {2'b00, m_flag});
            chk("R2 random nibble", reg_rdata, exp_nibble(m_mode, m_flag));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule